// File: doc/BRIEF.md
# Flash Read-While-Write Access Controller

This block stands between a read bus and a flash array that is split into partitions, each made of several blocks. While a program or erase is running in one partition, reads to every other partition are still served from the array. A read that lands in the partition under high-voltage operation is refused with an error response, and a sticky status flag records the event until software clears it. The block also decodes word addresses into partition, block and word fields. A block that does not exist in a non-power-of-two array returns a fixed filler pattern instead of data.

A write operation is framed by the mode bits (program, erase, program-suspend, erase-suspend) and a high-voltage-busy flag, all supplied by the surrounding configuration logic. The first interlock write latches the target word and its partition. Completing the operation applies the program (bits go only from 1 to 0) or the block erase to an internal synthesizable array model. Aborting releases the latch with no change to the array. The default geometry is 4 partitions of 2 blocks of 16 words, with the eighth block absent, so that every partition edge and the missing block can be reached in simulation.

Top module: `rww_read_ctrl`

## Requirements
- R1: After reset rd_ack_o, rd_err_o and rwe_o are 0 and every present word reads as all ones.
- R2: A request sampled on rd_req_i at a clock edge gives exactly one cycle of rd_ack_o after that edge, carrying rd_data_o and rd_err_o. With no request there is no acknowledge.
- R3: While program and erase are both clear, every read is served without error.
- R4: An interlock write while program or erase is set and nothing is latched captures the word address and its partition. Further interlock writes are ignored until completion or abort. With the default geometry the partition is address bits [6:5], the block is bits [6:4] and the word is bits [3:0].
- R5: With program or erase set, high voltage busy, a latched target and no suspend, a read to the latched partition responds with rd_err_o=1 and rd_data_o=0. Reads to any other partition are served normally.
- R6: With program and program-suspend both set, reads to every partition are served without error.
- R7: With erase and erase-suspend set and program clear, reads to every partition are served. Erase-suspend does not suspend while program is set.
- R8: rwe_o is set by every error response and stays set until a rwe_clr_i pulse. When an error and a clear occur in the same cycle, the set takes precedence.
- R9: Completion of a latched program stores the old word AND the interlock data, so bits change only from 1 to 0. Program takes precedence if both mode bits were set at latch time.
- R10: Completion of a latched erase sets every word of the latched block to all ones and leaves other blocks unchanged.
- R11: An abort leaves the array unchanged and releases the latch. Abort takes precedence over a same-cycle completion.
- R12: A read to an absent block (block index at or above BLKS_PRESENT) that is not refused returns 32'hDEAD_BEEF without error. An interlock write to an absent block latches its partition, but completion writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pgm_i | input | 1 | Program mode bit |
| cfg_ers_i | input | 1 | Erase mode bit |
| cfg_psus_i | input | 1 | Program-suspend bit |
| cfg_esus_i | input | 1 | Erase-suspend bit |
| hv_busy_i | input | 1 | High-voltage operation in progress |
| ilk_valid_i | input | 1 | Interlock write strobe |
| ilk_addr_i | input | ADDR_W (7) | Interlock word address |
| ilk_data_i | input | DATA_W (32) | Interlock program data |
| op_done_i | input | 1 | Operation completed, commit to array |
| op_abort_i | input | 1 | Operation aborted, release latch |
| rwe_clr_i | input | 1 | Write-one-to-clear pulse for the error flag |
| rd_req_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W (7) | Read word address |
| rd_ack_o | output | 1 | Read response valid |
| rd_err_o | output | 1 | Read refused (error response) |
| rd_data_o | output | DATA_W (32) | Read data |
| rwe_o | output | 1 | Sticky read-while-write error flag |

## Verification
The bench aims at the partition edges: the last word of a latched partition and the first word of the next. A decoder that took the wrong address bits would refuse a legal read or serve a forbidden one. It covers both suspend states, and the case of program set during erase-suspend, where a controller that ignored the program bit would wrongly let reads through. It checks that a second interlock write is ignored, that an abort frees the partition without writing, that a program can only clear bits, and that an erase stays inside its block. It also checks that an error and a clear in the same cycle leave the flag set, and that the absent block returns the filler pattern and takes no writes.

// File: rtl/rww_pkg.sv
package rww_pkg;

  // Kind of array operation captured by the interlock latch
  typedef enum logic [1:0] {
    OPK_NONE  = 2'd0,
    OPK_PROG  = 2'd1,
    OPK_ERASE = 2'd2
  } op_kind_e;

  // Read gating is lifted while an operation is suspended
  function automatic logic rd_suspended(input logic pgm, input logic ers,
                                        input logic psus, input logic esus);
    return (pgm & psus) | (ers & esus & ~pgm);
  endfunction

endpackage

// File: rtl/rww_addr_decode.sv
module rww_addr_decode #(
  parameter int PART_W       = 2,
  parameter int BSEL_W       = 1,
  parameter int WORD_W       = 4,
  parameter int BLKS_PRESENT = 7,
  localparam int BLK_W       = PART_W + BSEL_W,
  localparam int ADDR_W      = BLK_W + WORD_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [PART_W-1:0] part_o,
  output logic [BLK_W-1:0]  blk_o,
  output logic [WORD_W-1:0] word_o,
  output logic              present_o
);

  localparam logic [BLK_W:0] PRESENT_L = BLKS_PRESENT[BLK_W:0];

  always_comb begin
    word_o    = addr_i[WORD_W-1:0];
    blk_o     = addr_i[ADDR_W-1:WORD_W];
    part_o    = addr_i[ADDR_W-1 -: PART_W];
    present_o = ({1'b0, blk_o} < PRESENT_L);
  end

endmodule

// File: rtl/rww_gate.sv
module rww_gate
  import rww_pkg::*;
#(
  parameter int PART_W = 2,
  parameter int BLK_W  = 3,
  parameter int WORD_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgm_i,
  input  logic              ers_i,
  input  logic              psus_i,
  input  logic              esus_i,
  input  logic              hv_i,
  input  logic              ilk_valid_i,
  input  logic [PART_W-1:0] ilk_part_i,
  input  logic [BLK_W-1:0]  ilk_blk_i,
  input  logic [WORD_W-1:0] ilk_word_i,
  input  logic [DATA_W-1:0] ilk_data_i,
  input  logic              ilk_present_i,
  input  logic              op_done_i,
  input  logic              op_abort_i,
  input  logic              rd_req_i,
  input  logic [PART_W-1:0] rd_part_i,
  input  logic              rwe_clr_i,
  output logic              conflict_o,
  output logic              rwe_o,
  output logic              prog_en_o,
  output logic              erase_en_o,
  output logic [BLK_W-1:0]  wr_blk_o,
  output logic [WORD_W-1:0] wr_word_o,
  output logic [DATA_W-1:0] wr_data_o
);

  // Latched operation target
  logic              lat_valid_q, lat_valid_d;
  logic [PART_W-1:0] lat_part_q,  lat_part_d;
  logic [BLK_W-1:0]  lat_blk_q,   lat_blk_d;
  logic [WORD_W-1:0] lat_word_q,  lat_word_d;
  logic [DATA_W-1:0] lat_data_q,  lat_data_d;
  logic              lat_pres_q,  lat_pres_d;
  op_kind_e          lat_kind_q,  lat_kind_d;
  logic              rwe_q, rwe_d;

  logic op_active, suspended, capture, release_lat, commit, rwe_set;

  always_comb begin
    op_active   = pgm_i | ers_i;
    suspended   = rd_suspended(pgm_i, ers_i, psus_i, esus_i);
    capture     = ilk_valid_i & op_active & ~lat_valid_q;
    release_lat = lat_valid_q & (op_done_i | op_abort_i);
    commit      = lat_valid_q & op_done_i & ~op_abort_i & lat_pres_q;
    conflict_o  = lat_valid_q & op_active & hv_i & ~suspended &
                  (rd_part_i == lat_part_q);
    rwe_set     = rd_req_i & conflict_o;
  end

  // Latch next state
  always_comb begin
    lat_valid_d = lat_valid_q;
    lat_part_d  = lat_part_q;
    lat_blk_d   = lat_blk_q;
    lat_word_d  = lat_word_q;
    lat_data_d  = lat_data_q;
    lat_pres_d  = lat_pres_q;
    lat_kind_d  = lat_kind_q;
    if (release_lat) begin
      lat_valid_d = 1'b0;
      lat_kind_d  = OPK_NONE;
    end else if (capture) begin
      lat_valid_d = 1'b1;
      lat_part_d  = ilk_part_i;
      lat_blk_d   = ilk_blk_i;
      lat_word_d  = ilk_word_i;
      lat_data_d  = ilk_data_i;
      lat_pres_d  = ilk_present_i;
      lat_kind_d  = pgm_i ? OPK_PROG : OPK_ERASE;
    end
    rwe_d = rwe_set | (rwe_q & ~rwe_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_valid_q <= 1'b0;
      lat_part_q  <= '0;
      lat_blk_q   <= '0;
      lat_word_q  <= '0;
      lat_data_q  <= '0;
      lat_pres_q  <= 1'b0;
      lat_kind_q  <= OPK_NONE;
      rwe_q       <= 1'b0;
    end else begin
      lat_valid_q <= lat_valid_d;
      lat_kind_q  <= lat_kind_d;
      rwe_q       <= rwe_d;
      if (capture) begin
        lat_part_q <= lat_part_d;
        lat_blk_q  <= lat_blk_d;
        lat_word_q <= lat_word_d;
        lat_data_q <= lat_data_d;
        lat_pres_q <= lat_pres_d;
      end
    end
  end

  always_comb begin
    prog_en_o  = commit & (lat_kind_q == OPK_PROG);
    erase_en_o = commit & (lat_kind_q == OPK_ERASE);
    wr_blk_o   = lat_blk_q;
    wr_word_o  = lat_word_q;
    wr_data_o  = lat_data_q;
    rwe_o      = rwe_q;
  end

  // R4: a held latch keeps its partition until completion or abort
  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_valid_q && !op_done_i && !op_abort_i) |=> (lat_valid_q && $stable(lat_part_q)));

  // R8: flag stays set without a clear
  assert_rwe_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rwe_q && !rwe_clr_i) |=> rwe_q);

  // R11: abort always frees the latch
  assert_abort_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_abort_i |=> !lat_valid_q);

  // R9/R10: at most one commit kind per cycle
  assert_one_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_en_o, erase_en_o}));

endmodule

// File: rtl/rww_array.sv
module rww_array #(
  parameter int NBLK          = 8,
  parameter int BLKS_PRESENT  = 7,
  parameter int WORDS_PER_BLK = 16,
  parameter int DATA_W        = 32,
  parameter logic [DATA_W-1:0] INVALID_PAT = 32'hDEAD_BEEF,
  localparam int BLK_W  = $clog2(NBLK),
  localparam int WORD_W = $clog2(WORDS_PER_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  rd_blk_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              prog_en_i,
  input  logic              erase_en_i,
  input  logic [BLK_W-1:0]  wr_blk_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [DATA_W-1:0] wr_data_i
);

  logic [DATA_W-1:0] blk_rd [NBLK];

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    if (b < BLKS_PRESENT) begin : g_mem
      logic [DATA_W-1:0] mem_q [WORDS_PER_BLK];
      logic [DATA_W-1:0] mem_d [WORDS_PER_BLK];
      logic              sel, wr_en;

      always_comb begin
        sel   = (wr_blk_i == BLK_W'(b));
        wr_en = sel & (prog_en_i | erase_en_i);
        mem_d = mem_q;
        if (erase_en_i && sel) begin
          for (int w = 0; w < WORDS_PER_BLK; w++) mem_d[w] = '1;
        end else if (prog_en_i && sel) begin
          mem_d[wr_word_i] = mem_q[wr_word_i] & wr_data_i;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int w = 0; w < WORDS_PER_BLK; w++) mem_q[w] <= '1;
        end else if (wr_en) begin
          mem_q <= mem_d;
        end
      end

      assign blk_rd[b] = mem_q[rd_word_i];

      // R9: a program never sets a bit
      assert_prog_no_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en_i && sel) |=> ((mem_q[$past(wr_word_i)] & ~$past(mem_q[wr_word_i])) == '0));
    end else begin : g_absent
      assign blk_rd[b] = INVALID_PAT;
    end
  end

  assign rd_data_o = blk_rd[rd_blk_i];

endmodule

// File: rtl/rww_read_ctrl.sv
module rww_read_ctrl
  import rww_pkg::*;
#(
  parameter int PARTS         = 4,
  parameter int BLKS_PER_PART = 2,
  parameter int WORDS_PER_BLK = 16,
  parameter int BLKS_PRESENT  = 7,
  parameter int DATA_W        = 32,
  parameter logic [DATA_W-1:0] INVALID_PAT = 32'hDEAD_BEEF,
  localparam int PART_W = $clog2(PARTS),
  localparam int BSEL_W = $clog2(BLKS_PER_PART),
  localparam int WORD_W = $clog2(WORDS_PER_BLK),
  localparam int BLK_W  = PART_W + BSEL_W,
  localparam int ADDR_W = BLK_W + WORD_W,
  localparam int NBLK   = PARTS * BLKS_PER_PART
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pgm_i,
  input  logic              cfg_ers_i,
  input  logic              cfg_psus_i,
  input  logic              cfg_esus_i,
  input  logic              hv_busy_i,
  input  logic              ilk_valid_i,
  input  logic [ADDR_W-1:0] ilk_addr_i,
  input  logic [DATA_W-1:0] ilk_data_i,
  input  logic              op_done_i,
  input  logic              op_abort_i,
  input  logic              rwe_clr_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_ack_o,
  output logic              rd_err_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rwe_o
);

  logic [PART_W-1:0] rd_part, ilk_part;
  logic [BLK_W-1:0]  rd_blk, ilk_blk, wr_blk;
  logic [WORD_W-1:0] rd_word, ilk_word, wr_word;
  logic              rd_present, ilk_present;
  logic              conflict, prog_en, erase_en;
  logic [DATA_W-1:0] wr_data, arr_rdata;

  rww_addr_decode #(.PART_W(PART_W), .BSEL_W(BSEL_W), .WORD_W(WORD_W),
                    .BLKS_PRESENT(BLKS_PRESENT)) u_rd_dec (
    .addr_i(rd_addr_i), .part_o(rd_part), .blk_o(rd_blk),
    .word_o(rd_word), .present_o(rd_present));

  rww_addr_decode #(.PART_W(PART_W), .BSEL_W(BSEL_W), .WORD_W(WORD_W),
                    .BLKS_PRESENT(BLKS_PRESENT)) u_ilk_dec (
    .addr_i(ilk_addr_i), .part_o(ilk_part), .blk_o(ilk_blk),
    .word_o(ilk_word), .present_o(ilk_present));

  rww_gate #(.PART_W(PART_W), .BLK_W(BLK_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .pgm_i(cfg_pgm_i), .ers_i(cfg_ers_i), .psus_i(cfg_psus_i), .esus_i(cfg_esus_i),
    .hv_i(hv_busy_i),
    .ilk_valid_i(ilk_valid_i), .ilk_part_i(ilk_part), .ilk_blk_i(ilk_blk),
    .ilk_word_i(ilk_word), .ilk_data_i(ilk_data_i), .ilk_present_i(ilk_present),
    .op_done_i(op_done_i), .op_abort_i(op_abort_i),
    .rd_req_i(rd_req_i), .rd_part_i(rd_part), .rwe_clr_i(rwe_clr_i),
    .conflict_o(conflict), .rwe_o(rwe_o),
    .prog_en_o(prog_en), .erase_en_o(erase_en),
    .wr_blk_o(wr_blk), .wr_word_o(wr_word), .wr_data_o(wr_data));

  rww_array #(.NBLK(NBLK), .BLKS_PRESENT(BLKS_PRESENT), .WORDS_PER_BLK(WORDS_PER_BLK),
              .DATA_W(DATA_W), .INVALID_PAT(INVALID_PAT)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_blk_i(rd_blk), .rd_word_i(rd_word), .rd_data_o(arr_rdata),
    .prog_en_i(prog_en), .erase_en_i(erase_en),
    .wr_blk_i(wr_blk), .wr_word_i(wr_word), .wr_data_i(wr_data));

  // Response registers
  logic              ack_q, ack_d, err_q, err_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    ack_d  = rd_req_i;
    err_d  = rd_req_i & conflict;
    data_d = conflict ? '0 : arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else begin
      ack_q <= ack_d;
      err_q <= err_d;
      if (rd_req_i) data_q <= data_d;
    end
  end

  assign rd_ack_o  = ack_q;
  assign rd_err_o  = err_q;
  assign rd_data_o = data_q;

  // R2: one acknowledge per request, none without
  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |=> rd_ack_o);
  assert_no_spurious_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |=> !rd_ack_o);
  // R3: no operation, no error
  assert_idle_no_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && !cfg_pgm_i && !cfg_ers_i) |=> !rd_err_o);
  // R6: program suspend serves reads
  assert_psus_no_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && cfg_pgm_i && cfg_psus_i) |=> !rd_err_o);
  // R7: erase suspend serves reads
  assert_esus_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && cfg_ers_i && cfg_esus_i && !cfg_pgm_i) |=> !rd_err_o);
  // R5: an error response carries zero data
  assert_err_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err_o |-> (rd_ack_o && rd_data_o == '0));
  // R8: the flag rises only with an error response
  assert_rwe_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwe_o) |-> rd_err_o);
  // R12: absent block yields the filler pattern
  assert_invalid_pat_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && !rd_present && !conflict) |=> (rd_data_o == INVALID_PAT));

endmodule

// File: tb/sim_rww_read_ctrl.sv
module sim_rww_read_ctrl;

  localparam logic [31:0] ONES = 32'hFFFF_FFFF;
  localparam logic [31:0] PAT  = 32'hDEAD_BEEF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pgm = 0, ers = 0, psus = 0, esus = 0, hv = 0;
  logic ilk_v = 0, done = 0, abrt = 0, clr = 0, req = 0;
  logic [6:0]  ilk_a = '0, rd_a = '0;
  logic [31:0] ilk_d = '0;
  logic        ack, err, rwe;
  logic [31:0] rdata;

  int n_cmp = 0, n_bad = 0;
  logic [32:0] q_exp [$];
  string       q_tag [$];

  always #5 clk = ~clk;

  rww_read_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_pgm_i(pgm), .cfg_ers_i(ers), .cfg_psus_i(psus), .cfg_esus_i(esus),
    .hv_busy_i(hv), .ilk_valid_i(ilk_v), .ilk_addr_i(ilk_a), .ilk_data_i(ilk_d),
    .op_done_i(done), .op_abort_i(abrt), .rwe_clr_i(clr),
    .rd_req_i(req), .rd_addr_i(rd_a),
    .rd_ack_o(ack), .rd_err_o(err), .rd_data_o(rdata), .rwe_o(rwe));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pop expected response on each acknowledge
  always @(negedge clk) begin
    if (rst_n && ack === 1'b1) begin
      if (q_exp.size() == 0) begin
        chk(32'd1, 32'd0, "R2 unexpected ack");
      end else begin
        logic [32:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk({31'd0, err}, {31'd0, e[32]}, {t, " err"});
        chk(rdata, e[31:0], {t, " data"});
      end
    end
  end

  task automatic rd(input logic [6:0] a, input logic [31:0] d, input logic e,
                    input string tag);
    @(negedge clk);
    req = 1; rd_a = a;
    q_exp.push_back({e, d}); q_tag.push_back(tag);
    @(negedge clk);
    req = 0;
  endtask

  task automatic ilk(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); ilk_v = 1; ilk_a = a; ilk_d = d;
    @(negedge clk); ilk_v = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
  endtask

  task automatic prog_word(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); pgm = 1;
    ilk(a, d);
    pulse_done();
    @(negedge clk); pgm = 0;
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_cmp++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({31'd0, ack}, 0, "R1 ack reset");
    chk({31'd0, err}, 0, "R1 err reset");
    chk({31'd0, rwe}, 0, "R1 rwe reset");
    rst_n = 1;
    rd(7'h00, ONES, 0, "R1 R3 first word");
    rd(7'h6F, ONES, 0, "R1 R3 last present word");
    rd(7'h70, PAT, 0, "R12 absent block");
    rd(7'h7F, PAT, 0, "R12 absent block end");
    @(negedge clk);
    chk({31'd0, ack}, 0, "R2 no ack without request");

    // Program word 0x12 in partition 0
    pgm = 1;
    ilk(7'h12, 32'hA5A5_0F0F);
    hv = 1;
    rd(7'h25, ONES, 0, "R5 other partition");
    rd(7'h03, 32'h0, 1, "R5 same partition");
    chk({31'd0, rwe}, 1, "R8 rwe set");
    rd(7'h1F, 32'h0, 1, "R5 last word of partition");
    rd(7'h20, ONES, 0, "R5 first word of next partition");
    ilk(7'h30, 32'h0);
    rd(7'h3F, ONES, 0, "R4 second interlock ignored");
    rd(7'h05, 32'h0, 1, "R4 latch kept");
    psus = 1;
    rd(7'h12, ONES, 0, "R6 suspended own partition");
    rd(7'h05, ONES, 0, "R6 suspended other word");
    psus = 0;
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    chk({31'd0, rwe}, 0, "R8 rwe cleared");
    repeat (3) @(negedge clk);
    chk({31'd0, rwe}, 0, "R8 rwe stays clear");
    hv = 0;
    pulse_done();
    pgm = 0;
    rd(7'h12, 32'hA5A5_0F0F, 0, "R9 programmed");
    rd(7'h30, ONES, 0, "R4 ignored interlock not written");

    prog_word(7'h12, 32'hFFFF_00FF);
    rd(7'h12, 32'hA5A5_000F, 0, "R9 bits only cleared");
    prog_word(7'h44, 32'h0);
    prog_word(7'h50, 32'h1234_5678);
    rd(7'h44, 32'h0, 0, "R9 block 4 word");

    // Erase block 4 in partition 2
    ers = 1;
    ilk(7'h40, 32'h0);
    hv = 1;
    rd(7'h50, 32'h0, 1, "R5 erase partition other block");
    rd(7'h12, 32'hA5A5_000F, 0, "R5 read during erase");
    esus = 1;
    rd(7'h44, 32'h0, 0, "R7 erase suspended");
    pgm = 1;
    rd(7'h47, 32'h0, 1, "R7 program overrides erase suspend");
    pgm = 0; esus = 0;
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    @(negedge clk);
    req = 1; rd_a = 7'h41; clr = 1;
    q_exp.push_back({1'b1, 32'h0}); q_tag.push_back("R8 error with clear");
    @(negedge clk);
    req = 0; clr = 0;
    chk({31'd0, rwe}, 1, "R8 set wins over clear");
    hv = 0;
    pulse_done();
    ers = 0;
    rd(7'h44, ONES, 0, "R10 erased word");
    rd(7'h50, 32'h1234_5678, 0, "R10 neighbour block kept");

    // Abort
    pgm = 1;
    ilk(7'h30, 32'h0);
    hv = 1;
    rd(7'h31, 32'h0, 1, "R11 before abort");
    @(negedge clk); abrt = 1; done = 1;
    @(negedge clk); abrt = 0; done = 0;
    rd(7'h31, ONES, 0, "R11 latch released");
    hv = 0; pgm = 0;
    rd(7'h30, ONES, 0, "R11 abort wrote nothing");

    // Interlock to absent block
    pgm = 1;
    ilk(7'h70, 32'h0);
    hv = 1;
    rd(7'h60, 32'h0, 1, "R12 absent block partition locked");
    rd(7'h10, ONES, 0, "R12 other partition served");
    hv = 0;
    pulse_done();
    pgm = 0;
    rd(7'h70, PAT, 0, "R12 absent block unchanged");
    rd(7'h60, ONES, 0, "R12 present neighbour unchanged");

    repeat (3) @(negedge clk);
    chk(q_exp.size(), 0, "R2 all responses seen");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule